// File: doc/BRIEF.md
# Single-Level Page Table Translator

The translator turns a virtual word address into a physical one by looking up a linear page table that sits in main memory. The low bits of the virtual address are the offset within a 512-word page and the high bits are the virtual page number. The page number is added to the table base of the current user to give the address of the page table entry. The translator reads that entry from memory. If the entry is valid, it replaces the page number with the 5-bit frame number from the entry and issues the data access. If the entry is not valid, it ends the request with a page-fault response and makes no data access.

Every request therefore costs two memory transactions: one for the entry and one for the data word. There is no translation cache. A change of user is made by loading a new table base, and the base register accepts a write only while the translator is idle. The memory side uses a request/grant handshake for addresses and a read-valid pulse for completion. A data write also completes with a read-valid pulse.

The state machine has five states. ST_IDLE accepts a request and moves to ST_PTE_READ. ST_PTE_READ holds the entry read until it is granted, then moves to ST_PTE_WAIT. ST_PTE_WAIT waits for the entry data, then moves to ST_DATA_ACCESS if the entry is valid or to ST_FAULT if it is not. ST_DATA_ACCESS issues the translated access, waits for its completion, and returns to ST_IDLE. ST_FAULT returns to ST_IDLE after one cycle.

Top module: `ptx_translator`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: The first memory access of each request is a read (`mem_we`=0) at address table base + virtual page number, modulo 2^14. The virtual page number is `req_vaddr[14:9]`.
- R3: The page table entry keeps its valid flag in bit 15 and its frame number in bits 4:0. The data access goes to physical address {frame, `req_vaddr[8:0]`}, with the offset passed through unchanged.
- R4: A read request with a valid entry returns `rsp_fault`=0, the translated address on `rsp_paddr`, and on `rsp_rdata` the word that memory held at that address.
- R5: An entry with bit 15 clear gives `rsp_fault`=1 and `rsp_paddr`=0, and causes no memory access other than the entry read.
- R6: A request is taken only while `req_ready` is 1. A `req_valid` seen while busy causes no memory access and no response.
- R7: A write to the table base is applied only while idle. A write made while busy leaves the base unchanged for later requests.
- R8: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req` stays high and `mem_addr` stays the same. Each access is granted once.
- R9: `rsp_valid` is a one-cycle pulse. It appears in the cycle after the data access's `mem_rvalid` cycle, or two cycles after the `mem_rvalid` of an invalid entry.
- R10: A write request with a valid entry drives `mem_we`=1 and `mem_wdata`=`req_wdata` on the data access, and the word can then be read back through the same virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the page table base (honoured only when idle) |
| base_wdata | input | 14 | New page table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and accepting a request |
| req_vaddr | input | 15 | Virtual word address {page number, offset} |
| req_write | input | 1 | 1 = data write, 0 = data read |
| req_wdata | input | 16 | Data to write |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_addr | output | 14 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rvalid | input | 1 | Memory completion, read data valid |
| mem_rdata | input | 16 | Memory read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page fault: the entry was invalid |
| rsp_rdata | output | 16 | Data returned by the data access |
| rsp_paddr | output | 14 | Translated physical address (0 on a fault) |

## Verification
A wrong state in the sequencer shows at the memory port first. A skipped entry read, a grant taken twice, or a request that drops before its grant all change the addresses that memory sees within a cycle or two. The reference model compares the timing of `rsp_valid` on every clock against the completion cycles it observed. A state that lingers or advances early therefore shifts the response pulse by at least one cycle, and the shift is flagged in that same cycle. A latched frame or base that is wrong does not change the timing. It appears as a bad address in the grant log for the same request, or, for a base write made while busy, in the entry address of the next request.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_PTE_READ    = 3'd1,
        ST_PTE_WAIT    = 3'd2,
        ST_DATA_ACCESS = 3'd3,
        ST_FAULT       = 3'd4
    } ptx_state_e;
endpackage

// File: rtl/ptx_base_reg.sv
module ptx_base_reg #(
    parameter int PA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    output logic [PA_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (wr_en && idle)
            base <= wr_data;
    end

    // R7: the base register holds while a translation is in flight
    p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(base));
endmodule

// File: rtl/ptx_addr_split.sv
module ptx_addr_split #(
    parameter int VPN_W = 6,
    parameter int OFF_W = 9,
    parameter int PA_W  = 14
) (
    input  logic [VPN_W+OFF_W-1:0] vaddr,
    input  logic [PA_W-1:0]        base,
    output logic [OFF_W-1:0]       offset,
    output logic [PA_W-1:0]        pte_addr
);
    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn      = vaddr[VPN_W+OFF_W-1:OFF_W];
        offset   = vaddr[OFF_W-1:0];
        pte_addr = base + PA_W'(vpn);
    end
endmodule

// File: rtl/ptx_pte_decode.sv
module ptx_pte_decode #(
    parameter int FRAME_W = 5
) (
    input  logic               flag_bit,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               pte_valid,
    output logic [FRAME_W-1:0] pte_frame
);
    always_comb begin
        pte_valid = flag_bit;
        pte_frame = frame_bits;
    end
endmodule

// File: rtl/ptx_fsm.sv
module ptx_fsm
    import ptx_pkg::*;
#(
    parameter int OFF_W   = 9,
    parameter int FRAME_W = 5,
    parameter int DATA_W  = 16,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [PA_W-1:0]    pte_addr_in,
    input  logic               pte_valid,
    input  logic [FRAME_W-1:0] pte_frame,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic [PA_W-1:0]    mem_addr,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [PA_W-1:0]    rsp_paddr
);
    ptx_state_e state, state_nx;

    logic [PA_W-1:0]    pte_addr_q;
    logic [OFF_W-1:0]   offset_q;
    logic [FRAME_W-1:0] frame_q;
    logic               write_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               issued_q;
    logic [PA_W-1:0]    phys_addr;

    assign phys_addr = {frame_q, offset_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = pte_addr_q;
        mem_we    = 1'b0;
        mem_wdata = wdata_q;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_nx = ST_PTE_READ;
            end
            ST_PTE_READ: begin
                mem_req = 1'b1;
                if (mem_gnt) state_nx = ST_PTE_WAIT;
            end
            ST_PTE_WAIT: begin
                if (mem_rvalid)
                    state_nx = pte_valid ? ST_DATA_ACCESS : ST_FAULT;
            end
            ST_DATA_ACCESS: begin
                mem_addr = phys_addr;
                mem_req  = !issued_q;
                mem_we   = write_q;
                if (issued_q && mem_rvalid) state_nx = ST_IDLE;
            end
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured request fields and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_addr_q <= '0;
            offset_q   <= '0;
            frame_q    <= '0;
            write_q    <= 1'b0;
            wdata_q    <= '0;
            issued_q   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pte_addr_q <= pte_addr_in;
                        offset_q   <= req_offset;
                        write_q    <= req_write;
                        wdata_q    <= req_wdata;
                    end
                end
                ST_PTE_READ: ;
                ST_PTE_WAIT: begin
                    if (mem_rvalid) begin
                        frame_q  <= pte_frame;
                        issued_q <= 1'b0;
                    end
                end
                ST_DATA_ACCESS: begin
                    if (!issued_q && mem_gnt) issued_q <= 1'b1;
                    if (issued_q && mem_rvalid) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_rdata <= mem_rdata;
                        rsp_paddr <= phys_addr;
                    end
                end
                ST_FAULT: begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b1;
                    rsp_rdata <= '0;
                    rsp_paddr <= '0;
                end
                default: ;
            endcase
        end
    end

    // R2: an accepted request opens with the entry read at the split address
    p_pte_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req && !mem_we && mem_addr == $past(pte_addr_in));

    // R3: the data access targets the frame taken from the returned entry
    p_data_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PTE_WAIT && mem_rvalid && pte_valid
        |=> mem_req && mem_addr[PA_W-1 -: FRAME_W] == $past(pte_frame));

    // R5: an invalid entry gives a fault and no data access
    p_fault_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PTE_WAIT && mem_rvalid && !pte_valid
        |=> !mem_req ##1 (rsp_valid && rsp_fault && !mem_req));

    // R8: a request that has not been granted is held unchanged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: the response is a single-cycle pulse
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: an accepted request makes the translator busy
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
endmodule

// File: rtl/ptx_translator.sv
module ptx_translator #(
    parameter int VPN_W   = 6,
    parameter int OFF_W   = 9,
    parameter int FRAME_W = 5,
    parameter int DATA_W  = 16,
    localparam int PA_W   = FRAME_W + OFF_W,
    localparam int VA_W   = VPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [PA_W-1:0]   base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PA_W-1:0]   rsp_paddr
);
    logic [PA_W-1:0]    base;
    logic [OFF_W-1:0]   offset;
    logic [PA_W-1:0]    pte_addr;
    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;

    ptx_base_reg #(.PA_W(PA_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (req_ready),
        .wr_en   (base_we),
        .wr_data (base_wdata),
        .base    (base)
    );

    ptx_addr_split #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_split (
        .vaddr    (req_vaddr),
        .base     (base),
        .offset   (offset),
        .pte_addr (pte_addr)
    );

    ptx_pte_decode #(.FRAME_W(FRAME_W)) u_pte (
        .flag_bit   (mem_rdata[DATA_W-1]),
        .frame_bits (mem_rdata[FRAME_W-1:0]),
        .pte_valid  (pte_valid),
        .pte_frame  (pte_frame)
    );

    ptx_fsm #(.OFF_W(OFF_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_offset  (offset),
        .pte_addr_in (pte_addr),
        .pte_valid   (pte_valid),
        .pte_frame   (pte_frame),
        .mem_req     (mem_req),
        .mem_gnt     (mem_gnt),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (rsp_fault),
        .rsp_rdata   (rsp_rdata),
        .rsp_paddr   (rsp_paddr)
    );
endmodule

// File: tb/tb_ptx_translator.sv
module tb_ptx_translator;
    localparam int PA_W   = 14;
    localparam int VA_W   = 15;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_we = 1'b0;
    logic [PA_W-1:0]   base_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              mem_req;
    logic              mem_gnt = 1'b0;
    logic [PA_W-1:0]   mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [DATA_W-1:0] rsp_rdata;
    logic [PA_W-1:0]   rsp_paddr;

    always #10 clk = ~clk;  // 50 MHz

    ptx_translator dut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // behavioural memory
    int unsigned mem [int];
    function automatic int rd(input int a);
        return mem.exists(a) ? int'(mem[a]) : 0;
    endfunction

    // responder and cycle-by-cycle reference of the response timing
    int gnt_wait = 0;
    int lat = 0;
    int wcnt = 0;
    bit pending = 0;
    int pcnt = 0;
    int hold_data = 0;
    int phase = 0;       // 0: next grant is the entry read, 1: data access
    bit pend_is_pte = 0;
    int rsp_due = 0;
    bit prev_wait = 0;
    int prev_addr = 0;
    int g_addr[$];
    int g_we[$];
    int g_wd[$];

    always @(negedge clk) begin
        if (rst_n) begin
            // R9: response pulse exactly where the model expects it
            chk(rsp_valid === (rsp_due == 1), "R9", "rsp_valid timing",
                int'(rsp_valid), int'(rsp_due == 1));
            if (rsp_due > 0) rsp_due--;
            // R8: an ungranted request is held steady
            if (prev_wait)
                chk(mem_req === 1'b1 && int'(mem_addr) == prev_addr, "R8",
                    "held request", int'(mem_addr), prev_addr);
        end
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        prev_wait  = 0;
        if (pending) begin
            if (pcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = DATA_W'(hold_data);
                pending    = 0;
                if (pend_is_pte) begin
                    if (hold_data[15]) phase = 1;
                    else begin phase = 0; rsp_due = 2; end
                end else begin
                    phase = 0; rsp_due = 1;
                end
            end else pcnt--;
        end else if (rst_n && mem_req === 1'b1) begin
            if (wcnt >= gnt_wait) begin
                mem_gnt = 1'b1;
                wcnt    = 0;
                g_addr.push_back(int'(mem_addr));
                g_we.push_back(int'(mem_we));
                g_wd.push_back(int'(mem_wdata));
                pend_is_pte = (phase == 0);
                if (mem_we) begin
                    mem[int'(mem_addr)] = int'(mem_wdata);
                    hold_data = 0;
                end else hold_data = rd(int'(mem_addr));
                pending = 1;
                pcnt    = lat;
            end else begin
                wcnt++;
                prev_wait = 1;
                prev_addr = int'(mem_addr);
            end
        end
    end

    task automatic set_base(input int b);
        @(negedge clk);
        base_we    = 1'b1;
        base_wdata = PA_W'(b);
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic xlate(input int vpn, input int off, input bit wr, input int wd,
                         input int base, input bit poke, input string tag);
        int pte_a, pte, paddr, exp_rd;
        bit v;
        pte_a  = (base + vpn) % (1 << PA_W);
        pte    = rd(pte_a);
        v      = pte[15];
        paddr  = (pte & 31) * 512 + off;
        exp_rd = rd(paddr);
        g_addr.delete(); g_we.delete(); g_wd.delete();
        @(negedge clk);
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VA_W'((vpn << 9) | off);
        req_write = wr;
        req_wdata = DATA_W'(wd);
        @(negedge clk);
        // R6: busy after acceptance
        chk(req_ready === 1'b0, "R6", "busy after accept", int'(req_ready), 0);
        if (poke) begin
            req_vaddr  = VA_W'((7 << 9) | 3);
            base_we    = 1'b1;
            base_wdata = PA_W'(14'h0300);
            @(negedge clk);
            base_we = 1'b0;
        end
        req_valid = 1'b0;
        while (rsp_valid !== 1'b1) @(negedge clk);
        // R2: entry read address and direction
        chk(g_addr.size() >= 1 && g_addr[0] == pte_a && g_we[0] == 0, "R2",
            {tag, " entry address"}, g_addr.size() ? g_addr[0] : -1, pte_a);
        if (v) begin
            chk(g_addr.size() == 2, "R6", {tag, " access count"}, g_addr.size(), 2);
            if (g_addr.size() == 2) begin
                chk(g_addr[1] == paddr, "R3", {tag, " physical address"}, g_addr[1], paddr);
                chk(g_we[1] == int'(wr), "R10", {tag, " data direction"}, g_we[1], int'(wr));
                if (wr) chk(g_wd[1] == wd, "R10", {tag, " write data"}, g_wd[1], wd);
            end
            chk(rsp_fault === 1'b0, "R4", {tag, " fault flag"}, int'(rsp_fault), 0);
            chk(int'(rsp_paddr) == paddr, "R4", {tag, " rsp_paddr"}, int'(rsp_paddr), paddr);
            if (!wr) chk(int'(rsp_rdata) == exp_rd, "R4", {tag, " read data"},
                         int'(rsp_rdata), exp_rd);
        end else begin
            chk(g_addr.size() == 1, "R5", {tag, " no data access"}, g_addr.size(), 1);
            chk(rsp_fault === 1'b1, "R5", {tag, " fault flag"}, int'(rsp_fault), 1);
            chk(rsp_paddr === '0, "R5", {tag, " fault paddr"}, int'(rsp_paddr), 0);
        end
        chk(req_ready === 1'b1, "R6", {tag, " idle with response"}, int'(req_ready), 1);
    endtask

    function automatic int pte_val(input bit v, input int f, input int junk);
        return (int'(v) << 15) | (junk << 5) | f;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
        chk(mem_req === 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_req === 1'b0, "R1", "idle after reset",
            int'(req_ready), 1);

        // user A tables
        mem[14'h100 + 3]  = pte_val(1, 7, 0);
        mem[14'h100 + 10] = pte_val(1, 31, 0);
        mem[14'h100 + 5]  = pte_val(1, 0, 0);
        mem[14'h100 + 8]  = pte_val(0, 9, 0);
        mem[14'h100 + 9]  = pte_val(0, 31, 1023);
        mem[7 * 512 + 5]  = 16'hBEEF;
        mem[31 * 512 + 511] = 16'h5A5A;
        // user B tables
        mem[14'h200 + 3]  = pte_val(1, 12, 55);
        mem[12 * 512 + 5] = 16'hC0DE;
        // wrapped table
        mem[1]            = pte_val(1, 2, 0);
        mem[2 * 512]      = 16'h0F0F;

        set_base(14'h100);
        xlate(3, 5, 0, 0, 14'h100, 0, "read fast");                   // R4
        gnt_wait = 3; lat = 2;
        xlate(10, 511, 0, 0, 14'h100, 0, "read slow, top offset");    // R3 R8
        gnt_wait = 1; lat = 0;
        xlate(5, 0, 1, 16'h1234, 14'h100, 0, "write");                // R10
        xlate(5, 0, 0, 0, 14'h100, 0, "read back");                   // R10
        chk(rsp_rdata === 16'h1234, "R10", "read back value", int'(rsp_rdata), 16'h1234);
        xlate(8, 17, 0, 0, 14'h100, 0, "invalid entry");              // R5
        gnt_wait = 2; lat = 3;
        xlate(9, 1, 1, 16'hFFFF, 14'h100, 0, "invalid, frame bits set"); // R5
        gnt_wait = 0; lat = 1;
        set_base(14'h200);                                            // user switch
        xlate(3, 5, 0, 0, 14'h200, 0, "user switch");                 // R7
        xlate(3, 5, 0, 0, 14'h200, 1, "busy poke");                   // R6 R7
        xlate(3, 5, 0, 0, 14'h200, 0, "base kept after busy write");  // R7
        set_base(14'h3FFF);
        xlate(2, 0, 0, 0, 14'h3FFF, 0, "base wrap");                  // R2
        repeat (5) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule